// File: doc/BRIEF.md
# Paged Memory Management Unit

This block sits between an 8-bit CPU with a 16-bit address bus and a larger physical program memory. One 16 KiB region of the CPU address space is a movable window: an 8-bit page register chooses which 16 KiB physical page appears there. That gives up to 256 pages, 4 MB in all. Every other CPU address goes through to the bottom of physical memory unchanged.

Next to the window, a 22-bit linear pointer and a data port let the CPU read or write any physical byte without touching the page register. The pointer can advance by one after each data-port access.

A call/return sequencer makes paged subroutine calls atomic. A paged call pushes the return program counter and the current page, then switches to the new page and target. A paged return pops the page and program counter in the reverse order. Both run as one uninterruptible operation: the CPU port is stalled until the last stack byte has moved and the new page and PC take effect together.

Because a paged return pops one more byte than an ordinary return, software must enter a routine that ends in a paged return through a paged call. This holds even when caller and callee share a page.

Top module: `paged_mmu`

## Requirements
- R1: After reset the page register reads 0x00, all three linear pointer bytes read 0x00 and the control register reads 0x00.
- R2: A CPU access whose address lies in 0x8000 to 0xBFFF reaches the memory port at physical address {page, cpu_addr[13:0]} (page in bits 21:14).
- R3: A CPU access outside the window (and outside the register block) reaches the memory port at the CPU address zero-extended to 22 bits.
- R4: The registers occupy REG_BASE+0 to REG_BASE+5. Each offset holds:
  - +0: page register.
  - +1: pointer bits 21:16 (upper two bits read 0).
  - +2: pointer bits 15:8.
  - +3: pointer bits 7:0.
  - +4: data port.
  - +5: control register, bit 0 = auto-increment.

  Accesses to offsets +0 to +3 and +5 complete in the cycle they are presented and raise no memory request.
- R5: A data-port access reaches the memory port at the 22-bit pointer value, whatever the page register holds.
- R6: With control bit 0 set, each completed data-port access adds one to the pointer, wrapping from 0x3FFFFF to 0. With the bit clear, the pointer is unchanged.
- R7: A paged call with stack pointer SP writes three bytes, each through normal translation:
  - return-PC low byte at SP;
  - return-PC high byte at SP-1;
  - old page at SP-2.

  It reports done_sp = SP-3 and done_pc = target, and the page register then holds the new page.
- R8: A paged return with stack pointer SP reads three bytes:
  - the page from SP+1;
  - the PC high byte from SP+2;
  - the PC low byte from SP+3.

  It reports done_sp = SP+3 and done_pc = the popped PC, and the page register then holds the popped page.
- R9: From the cycle a call/return is accepted until done_valid falls, cpu_ready is low and no CPU request reaches the memory port.
- R10: With mem_ready held high, done_valid is high for exactly one cycle, the 4th after acceptance. The page register takes its new value at the end of that cycle. Under memory back-pressure each stack byte waits for mem_ready, and the result is unchanged.
- R11: For a CPU access forwarded to memory, cpu_ready follows mem_ready. The CPU holds its request until cpu_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_valid | input | 1 | CPU access request |
| cpu_ready | output | 1 | CPU access completes this cycle |
| cpu_we | input | 1 | 1 = write |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data, valid while cpu_ready |
| op_valid | input | 1 | Call/return request |
| op_ready | output | 1 | Sequencer idle, request accepted |
| op_ret | input | 1 | 1 = paged return, 0 = paged call |
| op_sp | input | 16 | Stack pointer at start |
| op_ret_pc | input | 16 | Return PC to push (call) |
| op_target | input | 16 | Call target PC |
| op_page | input | 8 | Call target page |
| done_valid | output | 1 | One-cycle completion pulse |
| done_pc | output | 16 | New program counter |
| done_sp | output | 16 | New stack pointer |
| mem_valid | output | 1 | Memory request |
| mem_ready | input | 1 | Memory accepts request |
| mem_we | output | 1 | 1 = write |
| mem_addr | output | 22 | Physical address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid while mem_ready |

## Verification
CPU accesses are combinational through the block. Translated address, register read data and ready therefore appear in the same cycle the request is presented, and the bench samples them mid-cycle before the accepting edge. A pointer increment or page write shows up on a read issued in a later cycle. For a call or return, the bench counts cycles from the accepting edge and expects done_valid in the 4th one when memory never stalls. It reads the page register only after that cycle's closing edge. Under back-pressure it checks only that completion comes later and that the stack bytes are the same.

// File: rtl/mmu_pkg.sv
`timescale 1ns/1ps
package mmu_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_XFER = 2'd1,
    SQ_DONE = 2'd2
  } seq_state_t;

  localparam int REG_PAGE_OFF = 0;
  localparam int REG_PTR_OFF  = 1;
endpackage

// File: rtl/mmu_xlate.sv
`timescale 1ns/1ps
module mmu_xlate #(
  parameter int CPU_AW  = 16,
  parameter int OFF_W   = 14,
  parameter int PAGE_W  = 8,
  parameter int PHYS_AW = PAGE_W + OFF_W,
  parameter logic [CPU_AW-1:0] WIN_BASE = 16'h8000
) (
  input  logic [CPU_AW-1:0]  addr,
  input  logic [PAGE_W-1:0]  page,
  output logic               in_win,
  output logic [PHYS_AW-1:0] phys
);
  localparam int SEL_W = CPU_AW - OFF_W;

  assign in_win = (addr[CPU_AW-1:OFF_W] == WIN_BASE[CPU_AW-1:OFF_W]);

  generate
    if (PHYS_AW >= CPU_AW) begin : g_ext
      assign phys = in_win ? {page, addr[OFF_W-1:0]}
                           : {{(PHYS_AW-CPU_AW){1'b0}}, addr};
    end else begin : g_trunc
      assign phys = in_win ? {page, addr[OFF_W-1:0]} : addr[PHYS_AW-1:0];
    end
  endgenerate

  always_comb begin
    assert (!in_win || phys[OFF_W-1:0] == addr[OFF_W-1:0])  // R2
      else $error("AST_WIN_OFFSET");
  end

  logic [SEL_W-1:0] unused_sel;
  assign unused_sel = WIN_BASE[CPU_AW-1:OFF_W];
endmodule

// File: rtl/mmu_regs.sv
`timescale 1ns/1ps
module mmu_regs import mmu_pkg::*; #(
  parameter int DATA_W  = 8,
  parameter int PAGE_W  = 8,
  parameter int PHYS_AW = 22,
  parameter int REG_AW  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [REG_AW-1:0]  acc_off,
  input  logic               reg_wr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               ldata_fire,
  input  logic               pg_load,
  input  logic [PAGE_W-1:0]  pg_val,
  output logic [PAGE_W-1:0]  page_q,
  output logic [PHYS_AW-1:0] lptr_q,
  output logic               is_ldata,
  output logic [DATA_W-1:0]  rdata
);
  localparam int NB        = (PHYS_AW + DATA_W - 1) / DATA_W;
  localparam int LDATA_OFF = REG_PTR_OFF + NB;
  localparam int CTRL_OFF  = REG_PTR_OFF + NB + 1;

  logic               auto_q;
  logic               page_wr, ctrl_wr;
  logic [PHYS_AW-1:0] ptr_step, lptr_d;
  logic [DATA_W-1:0]  lane_rd [NB];

  assign page_wr  = reg_wr && (acc_off == REG_AW'(REG_PAGE_OFF));
  assign ctrl_wr  = reg_wr && (acc_off == REG_AW'(CTRL_OFF));
  assign is_ldata = (acc_off == REG_AW'(LDATA_OFF));
  assign ptr_step = (ldata_fire && auto_q) ? lptr_q + PHYS_AW'(1) : lptr_q;

  // one byte lane per pointer byte; the top lane may be narrower
  for (genvar k = 0; k < NB; k++) begin : g_lane
    localparam int LO = k * DATA_W;
    localparam int LW = (PHYS_AW - LO < DATA_W) ? (PHYS_AW - LO) : DATA_W;
    logic wr_k;
    assign wr_k = reg_wr && (acc_off == REG_AW'(REG_PTR_OFF + NB - 1 - k));
    assign lptr_d[LO +: LW] = wr_k ? wdata[LW-1:0] : ptr_step[LO +: LW];
    assign lane_rd[k] = DATA_W'(lptr_q[LO +: LW]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      lptr_q <= '0;
      auto_q <= 1'b0;
    end else begin
      lptr_q <= lptr_d;
      if (pg_load)      page_q <= pg_val;
      else if (page_wr) page_q <= wdata[PAGE_W-1:0];
      if (ctrl_wr)      auto_q <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    if (acc_off == REG_AW'(REG_PAGE_OFF)) rdata = DATA_W'(page_q);
    if (acc_off == REG_AW'(CTRL_OFF))     rdata = DATA_W'(auto_q);
    for (int k = 0; k < NB; k++) begin
      if (acc_off == REG_AW'(REG_PTR_OFF + NB - 1 - k)) rdata = lane_rd[k];
    end
  end

  AST_PAGE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(page_q) |-> $past(pg_load || page_wr))  // R4
    else $error("AST_PAGE_SOURCE");
  AST_PTR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lptr_q) |-> $past(ldata_fire || reg_wr))  // R6
    else $error("AST_PTR_SOURCE");
endmodule

// File: rtl/mmu_callseq.sv
`timescale 1ns/1ps
module mmu_callseq import mmu_pkg::*; #(
  parameter int CPU_AW = 16,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              op_ret,
  input  logic [CPU_AW-1:0] op_sp,
  input  logic [CPU_AW-1:0] op_ret_pc,
  input  logic [CPU_AW-1:0] op_target,
  input  logic [PAGE_W-1:0] op_page,
  input  logic [PAGE_W-1:0] cur_page,
  output logic              op_ready,
  output logic              busy,
  output logic              req_valid,
  output logic              req_we,
  output logic [CPU_AW-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done_valid,
  output logic [CPU_AW-1:0] done_pc,
  output logic [CPU_AW-1:0] done_sp,
  output logic              pg_load,
  output logic [PAGE_W-1:0] pg_val
);
  localparam int NPCB  = CPU_AW / DATA_W;
  localparam int STEPS = NPCB + 1;
  localparam int CNT_W = $clog2(STEPS + 1);

  seq_state_t        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ret_q;
  logic [CPU_AW-1:0] sp_q, sp0_q, pc_q, tgt_q;
  logic [PAGE_W-1:0] pg_q, newpg_q;
  logic              fire;

  assign op_ready   = (state_q == SQ_IDLE);
  assign busy       = (state_q != SQ_IDLE);
  assign req_valid  = (state_q == SQ_XFER);
  assign req_we     = !ret_q;
  assign req_addr   = ret_q ? sp_q + CPU_AW'(1) : sp_q;
  assign fire       = req_valid && mem_ready;
  assign done_valid = (state_q == SQ_DONE);
  assign done_pc    = ret_q ? pc_q : tgt_q;
  assign done_sp    = sp_q;
  assign pg_load    = done_valid;
  assign pg_val     = ret_q ? pg_q : newpg_q;

  // call pushes PC bytes low first, then the page
  always_comb begin
    req_wdata = DATA_W'(pg_q);
    if (int'(cnt_q) < NPCB) req_wdata = pc_q[int'(cnt_q)*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      ret_q   <= 1'b0;
      sp_q    <= '0;
      sp0_q   <= '0;
      pc_q    <= '0;
      tgt_q   <= '0;
      pg_q    <= '0;
      newpg_q <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: if (op_valid) begin
          ret_q   <= op_ret;
          sp_q    <= op_sp;
          sp0_q   <= op_sp;
          pc_q    <= op_ret ? '0 : op_ret_pc;
          pg_q    <= cur_page;
          tgt_q   <= op_target;
          newpg_q <= op_page;
          cnt_q   <= '0;
          state_q <= SQ_XFER;
        end
        SQ_XFER: if (fire) begin
          cnt_q <= cnt_q + CNT_W'(1);
          sp_q  <= ret_q ? sp_q + CPU_AW'(1) : sp_q - CPU_AW'(1);
          // return pops the page first, then PC bytes high first
          if (ret_q) begin
            if (cnt_q == '0) pg_q <= mem_rdata[PAGE_W-1:0];
            else pc_q[(NPCB - int'(cnt_q))*DATA_W +: DATA_W] <= mem_rdata;
          end
          if (cnt_q == CNT_W'(STEPS - 1)) state_q <= SQ_DONE;
        end
        SQ_DONE: state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  AST_SP_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> done_sp == (ret_q ? sp0_q + CPU_AW'(STEPS) : sp0_q - CPU_AW'(STEPS)))  // R7
    else $error("AST_SP_BALANCE");
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !mem_ready |=> req_valid && $stable(req_addr) && $stable(req_wdata))  // R10
    else $error("AST_REQ_HOLD");
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid && op_ready)  // R10
    else $error("AST_DONE_SINGLE");
endmodule

// File: rtl/paged_mmu.sv
`timescale 1ns/1ps
module paged_mmu import mmu_pkg::*; #(
  parameter int CPU_AW  = 16,
  parameter int DATA_W  = 8,
  parameter int PAGE_W  = 8,
  parameter int OFF_W   = 14,
  parameter int PHYS_AW = PAGE_W + OFF_W,
  parameter int REG_AW  = 3,
  parameter logic [CPU_AW-1:0] WIN_BASE = 16'h8000,
  parameter logic [CPU_AW-1:0] REG_BASE = 16'h0070
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_valid,
  output logic               cpu_ready,
  input  logic               cpu_we,
  input  logic [CPU_AW-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic [DATA_W-1:0]  cpu_rdata,
  input  logic               op_valid,
  output logic               op_ready,
  input  logic               op_ret,
  input  logic [CPU_AW-1:0]  op_sp,
  input  logic [CPU_AW-1:0]  op_ret_pc,
  input  logic [CPU_AW-1:0]  op_target,
  input  logic [PAGE_W-1:0]  op_page,
  output logic               done_valid,
  output logic [CPU_AW-1:0]  done_pc,
  output logic [CPU_AW-1:0]  done_sp,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic               mem_we,
  output logic [PHYS_AW-1:0] mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata
);
  localparam int REG_SPAN = 1 << REG_AW;

  logic [CPU_AW-1:0]  rel, seq_addr, xl_addr;
  logic               reg_hit, is_ldata, reg_local, path_en, to_mem;
  logic               reg_wr, ldata_fire, busy;
  logic               seq_valid, seq_we, pg_load, in_win;
  logic [DATA_W-1:0]  seq_wdata, reg_rdata;
  logic [PAGE_W-1:0]  page_q, pg_val;
  logic [PHYS_AW-1:0] lptr_q, xl_phys;

  assign rel        = cpu_addr - REG_BASE;
  assign reg_hit    = (rel < CPU_AW'(REG_SPAN));
  assign reg_local  = reg_hit && !is_ldata;
  assign path_en    = !busy && !op_valid;
  assign to_mem     = path_en && cpu_valid && !reg_local;
  assign reg_wr     = path_en && cpu_valid && reg_local && cpu_we;
  assign ldata_fire = path_en && cpu_valid && reg_hit && is_ldata && mem_ready;

  assign cpu_ready  = path_en && (reg_local || mem_ready);
  assign cpu_rdata  = reg_local ? reg_rdata : mem_rdata;

  assign xl_addr    = busy ? seq_addr : cpu_addr;
  assign mem_valid  = busy ? seq_valid : to_mem;
  assign mem_we     = busy ? seq_we : cpu_we;
  assign mem_wdata  = busy ? seq_wdata : cpu_wdata;
  assign mem_addr   = (!busy && reg_hit) ? lptr_q : xl_phys;

  mmu_xlate #(
    .CPU_AW(CPU_AW), .OFF_W(OFF_W), .PAGE_W(PAGE_W),
    .PHYS_AW(PHYS_AW), .WIN_BASE(WIN_BASE)
  ) u_xlate (
    .addr(xl_addr), .page(page_q), .in_win(in_win), .phys(xl_phys)
  );

  mmu_regs #(
    .DATA_W(DATA_W), .PAGE_W(PAGE_W), .PHYS_AW(PHYS_AW), .REG_AW(REG_AW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .acc_off(rel[REG_AW-1:0]), .reg_wr(reg_wr),
    .wdata(cpu_wdata), .ldata_fire(ldata_fire), .pg_load(pg_load),
    .pg_val(pg_val), .page_q(page_q), .lptr_q(lptr_q),
    .is_ldata(is_ldata), .rdata(reg_rdata)
  );

  mmu_callseq #(
    .CPU_AW(CPU_AW), .DATA_W(DATA_W), .PAGE_W(PAGE_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ret(op_ret),
    .op_sp(op_sp), .op_ret_pc(op_ret_pc), .op_target(op_target),
    .op_page(op_page), .cur_page(page_q), .op_ready(op_ready), .busy(busy),
    .req_valid(seq_valid), .req_we(seq_we), .req_addr(seq_addr),
    .req_wdata(seq_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .done_valid(done_valid), .done_pc(done_pc), .done_sp(done_sp),
    .pg_load(pg_load), .pg_val(pg_val)
  );

  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || op_valid) |-> !cpu_ready)  // R9
    else $error("AST_BUSY_STALL");
  AST_REG_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && reg_local && !busy) |-> !mem_valid)  // R4
    else $error("AST_REG_LOCAL");
  AST_FWD_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && path_en && !reg_local) |-> (cpu_ready == mem_ready) && mem_valid)  // R11
    else $error("AST_FWD_READY");
  AST_WIN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !busy && !reg_hit && in_win) |-> mem_addr[PHYS_AW-1:OFF_W] == page_q)  // R2
    else $error("AST_WIN_PAGE");
endmodule

// File: tb/paged_mmu_test.sv
`timescale 1ns/1ps
module paged_mmu_test;
  localparam logic [15:0] RB = 16'h0070;
  localparam logic [15:0] R_PAGE = RB + 16'd0, R_PHI = RB + 16'd1, R_PMID = RB + 16'd2,
                          R_PLO = RB + 16'd3, R_DATA = RB + 16'd4, R_CTRL = RB + 16'd5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic cpu_ready;
  logic [7:0] cpu_rdata;
  logic op_valid = 1'b0, op_ret = 1'b0;
  logic [15:0] op_sp = '0, op_ret_pc = '0, op_target = '0;
  logic [7:0] op_page = '0;
  logic op_ready, done_valid;
  logic [15:0] done_pc, done_sp;
  logic mem_valid, mem_we;
  logic mem_ready = 1'b1;
  logic [21:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  int checks = 0, errors = 0;
  int bp = 0;

  logic [7:0]  bmem [0:16383];
  logic [21:0] wlog_a [0:63];
  logic [7:0]  wlog_d [0:63];
  logic [21:0] rlog_a [0:63];
  logic [5:0]  wn = '0, rn = '0;

  always #10 clk = ~clk;  // 50 MHz

  paged_mmu uut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .op_valid(op_valid), .op_ready(op_ready),
    .op_ret(op_ret), .op_sp(op_sp), .op_ret_pc(op_ret_pc),
    .op_target(op_target), .op_page(op_page), .done_valid(done_valid),
    .done_pc(done_pc), .done_sp(done_sp), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model: indexed by the low 14 address bits
  assign mem_rdata = bmem[mem_addr[13:0]];
  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      if (mem_we) begin
        bmem[mem_addr[13:0]] <= mem_wdata;
        wlog_a[wn] <= mem_addr; wlog_d[wn] <= mem_wdata; wn <= wn + 6'd1;
      end else begin
        rlog_a[rn] <= mem_addr; rn <= rn + 6'd1;
      end
    end
  end
  always @(negedge clk) begin
    case (bp)
      1: mem_ready <= ~mem_ready;
      2: mem_ready <= 1'b0;
      default: mem_ready <= 1'b1;
    endcase
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cpu_acc(input logic [15:0] a, input logic we, input logic [7:0] wd,
                         output logic [7:0] rd, output logic [21:0] ma,
                         output logic mv, output int waits);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_addr = a; cpu_we = we; cpu_wdata = wd; waits = 0;
    forever begin
      #5;
      if (cpu_ready) break;
      waits++;
      @(negedge clk);
    end
    rd = cpu_rdata; ma = mem_addr; mv = mem_valid;
    @(posedge clk); #1;
    cpu_valid = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    logic [7:0] rd; logic [21:0] ma; logic mv; int w;
    cpu_acc(a, 1'b1, d, rd, ma, mv, w);
  endtask

  task automatic rdv(input logic [15:0] a, output logic [7:0] d);
    logic [21:0] ma; logic mv; int w;
    cpu_acc(a, 1'b0, 8'h00, d, ma, mv, w);
  endtask

  task automatic run_op(input logic ret, input logic [15:0] sp, input logic [15:0] rpc,
                        input logic [15:0] tgt, input logic [7:0] pg,
                        output int cyc, output logic [15:0] dpc, output logic [15:0] dsp,
                        output int stall_bad);
    @(negedge clk);
    op_valid = 1'b1; op_ret = ret; op_sp = sp; op_ret_pc = rpc; op_target = tgt; op_page = pg;
    #5; chk("R9 op_ready when idle", op_ready, 1);
    @(posedge clk); #1;
    op_valid = 1'b0;
    cpu_valid = 1'b1; cpu_addr = R_PAGE; cpu_we = 1'b0;  // probe: would complete if not stalled
    cyc = 0; stall_bad = 0;
    forever begin
      @(negedge clk); cyc++; #5;
      if (cpu_ready || op_ready && !done_valid) stall_bad++;
      if (done_valid || cyc > 40) break;
    end
    dpc = done_pc; dsp = done_sp;
    @(negedge clk);
    cpu_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 no mem request after reset", mem_valid, 0);
    chk("R1 done_valid low", done_valid, 0);
    rdv(R_PAGE, d); chk("R1 page reset", d, 8'h00);
    rdv(R_PHI, d);  chk("R1 ptr hi reset", d, 8'h00);
    rdv(R_PMID, d); chk("R1 ptr mid reset", d, 8'h00);
    rdv(R_PLO, d);  chk("R1 ptr lo reset", d, 8'h00);
    rdv(R_CTRL, d); chk("R1 ctrl reset", d, 8'h00);
  endtask

  task automatic t_regs;
    logic [7:0] rd; logic [21:0] ma; logic mv; int w;
    cpu_acc(R_PAGE, 1'b1, 8'h3A, rd, ma, mv, w);
    chk("R4 page write raises no mem request", mv, 0);
    chk("R4 page write no wait", w, 0);
    cpu_acc(R_PAGE, 1'b0, 8'h00, rd, ma, mv, w);
    chk("R4 page readback", rd, 8'h3A);
    chk("R4 page read raises no mem request", mv, 0);
  endtask

  task automatic t_window;
    logic [7:0] rd; logic [21:0] ma; logic mv; int w;
    cpu_acc(16'h8123, 1'b0, 8'h00, rd, ma, mv, w);
    chk("R2 window addr", ma, {8'h3A, 14'h0123});
    chk("R2 window read data", rd, 8'h77);
    cpu_acc(16'hBFFF, 1'b0, 8'h00, rd, ma, mv, w);
    chk("R2 window top edge", ma, {8'h3A, 14'h3FFF});
    cpu_acc(16'h7FFF, 1'b0, 8'h00, rd, ma, mv, w);
    chk("R3 below window", ma, 22'h007FFF);
    cpu_acc(16'hC000, 1'b0, 8'h00, rd, ma, mv, w);
    chk("R3 above window", ma, 22'h00C000);
    chk("R3 forwarded request valid", mv, 1);
  endtask

  task automatic t_linear;
    logic [7:0] rd; logic [21:0] ma; logic mv; int w;
    wr(R_PHI, 8'h2A); wr(R_PMID, 8'h12); wr(R_PLO, 8'h34);
    cpu_acc(R_DATA, 1'b0, 8'h00, rd, ma, mv, w);
    chk("R5 data port addr ignores page", ma, 22'h2A1234);
    chk("R5 data port read", rd, 8'hC3);
    rdv(R_PLO, rd); chk("R6 no increment when disabled", rd, 8'h34);
    wr(R_CTRL, 8'h01);
    cpu_acc(R_DATA, 1'b0, 8'h00, rd, ma, mv, w);
    chk("R6 first auto read addr", ma, 22'h2A1234);
    cpu_acc(R_DATA, 1'b0, 8'h00, rd, ma, mv, w);
    chk("R6 second auto read addr", ma, 22'h2A1235);
    chk("R6 second auto read data", rd, 8'h3C);
    rdv(R_PLO, rd); chk("R6 pointer advanced by two", rd, 8'h36);
    wr(R_DATA, 8'h5A);
    chk("R5 data port write addr", wlog_a[wn - 6'd1], 22'h2A1236);
    chk("R5 data port write data", wlog_d[wn - 6'd1], 8'h5A);
    wr(R_PHI, 8'hFF); wr(R_PMID, 8'hFF); wr(R_PLO, 8'hFF);
    rdv(R_PHI, rd); chk("R4 ptr hi holds 6 bits", rd, 8'h3F);
    cpu_acc(R_DATA, 1'b0, 8'h00, rd, ma, mv, w);
    chk("R6 top address", ma, 22'h3FFFFF);
    rdv(R_PHI, rd); chk("R6 wrap hi", rd, 8'h00);
    rdv(R_PLO, rd); chk("R6 wrap lo", rd, 8'h00);
    wr(R_CTRL, 8'h00);
  endtask

  task automatic t_call_ret(input int mode);
    int cyc, sb; logic [15:0] dpc, dsp; logic [7:0] rd; logic [5:0] w0, r0;
    wr(R_PAGE, 8'h05);
    bp = mode;
    w0 = wn;
    run_op(1'b0, 16'h0150, 16'h8456, 16'h9000, 8'h12, cyc, dpc, dsp, sb);
    if (mode == 0) chk("R10 call done in 4th cycle", cyc, 4);
    else chk("R10 call delayed by back-pressure", cyc > 4, 1);
    chk("R9 stalled during call", sb, 0);
    chk("R7 push1 addr", wlog_a[w0], 22'h000150);
    chk("R7 push1 pc low", wlog_d[w0], 8'h56);
    chk("R7 push2 addr", wlog_a[w0 + 6'd1], 22'h00014F);
    chk("R7 push2 pc high", wlog_d[w0 + 6'd1], 8'h84);
    chk("R7 push3 addr", wlog_a[w0 + 6'd2], 22'h00014E);
    chk("R7 push3 old page", wlog_d[w0 + 6'd2], 8'h05);
    chk("R7 done_pc", dpc, 16'h9000);
    chk("R7 done_sp", dsp, 16'h014D);
    bp = 0;
    rdv(R_PAGE, rd); chk("R7 new page", rd, 8'h12);
    bp = mode;
    r0 = rn;
    run_op(1'b1, 16'h014D, 16'h0000, 16'h0000, 8'h00, cyc, dpc, dsp, sb);
    if (mode == 0) chk("R10 return done in 4th cycle", cyc, 4);
    else chk("R10 return delayed by back-pressure", cyc > 4, 1);
    chk("R9 stalled during return", sb, 0);
    chk("R8 pop1 addr", rlog_a[r0], 22'h00014E);
    chk("R8 pop2 addr", rlog_a[r0 + 6'd1], 22'h00014F);
    chk("R8 pop3 addr", rlog_a[r0 + 6'd2], 22'h000150);
    chk("R8 done_pc", dpc, 16'h8456);
    chk("R8 done_sp", dsp, 16'h0150);
    bp = 0;
    rdv(R_PAGE, rd); chk("R8 restored page", rd, 8'h05);
  endtask

  task automatic t_cpu_bp;
    logic [7:0] rd; logic [21:0] ma; logic mv; int w;
    wr(R_PAGE, 8'h3A);
    bp = 2;
    @(negedge clk); @(negedge clk);
    fork
      cpu_acc(16'h8123, 1'b0, 8'h00, rd, ma, mv, w);
      begin repeat (3) @(negedge clk); bp = 0; end
    join
    chk("R11 cpu waited for mem_ready", w >= 2, 1);
    chk("R11 read data after wait", rd, 8'h77);
    chk("R11 addr held during wait", ma, {8'h3A, 14'h0123});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16384; i++) bmem[i] = 8'h00;
    bmem[14'h0123] = 8'h77;
    bmem[14'h1234] = 8'hC3;
    bmem[14'h1235] = 8'h3C;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_regs;
    t_window;
    t_linear;
    t_call_ret(0);
    t_call_ret(1);
    t_cpu_bp;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule